// File: doc/BRIEF.md
# FIFO Threshold DMA Request Controller

This block keeps two byte queues for a serial peripheral: an outbound queue filled from the system bus and drained by the serial shifter, and an inbound queue filled by the shifter and drained from the bus. Each queue has its own controls: a serial-side enable, a one-cycle flush strobe, a threshold value and a DMA enable. Each queue also reports its occupancy.

The outbound side asks the DMA engine for more data while its queue holds fewer bytes than its threshold. The inbound side asks the DMA engine to collect data while its queue holds more bytes than its threshold. A flush strobe or a cleared DMA enable cancels a request that is already pending. Each direction also has a plain threshold-hit flag and two sticky error flags, one for overflow and one for underflow.

Each queue is tracked by an occupancy state machine with three states: `FS_EMPTY`, `FS_PART` and `FS_FULL`.
- An accepted push moves it from `FS_EMPTY` to `FS_PART`, or to `FS_FULL` at depth 1.
- A push without a pop at one below depth moves it from `FS_PART` to `FS_FULL`.
- A pop without a push at one entry moves it from `FS_PART` to `FS_EMPTY`.
- An accepted pop moves it from `FS_FULL` to `FS_PART`.
- A flush returns it to `FS_EMPTY` from any state.

Each request is driven by a state machine with three states: `RQ_OFF`, `RQ_WAIT` and `RQ_ASSERT`.
- From any state it goes to `RQ_OFF` when the DMA enable is 0.
- It goes to `RQ_WAIT` on a flush while enabled.
- Otherwise it goes to `RQ_ASSERT` when the compare on the post-edge level holds, and to `RQ_WAIT` when it does not.

Top module: `fifo_dma_ctl`

## Requirements
- R1: `tx_hit` is 1 exactly when `tx_level < tx_thresh`. One cycle after an edge with `tx_dma_en`=1 and no `tx_flush`, `tx_dma_req` equals (`tx_level` after that edge < the `tx_thresh` sampled at that edge).
- R2: `rx_hit` is 1 exactly when `rx_level > rx_thresh`. One cycle after an edge with `rx_dma_en`=1 and no `rx_flush`, `rx_dma_req` equals (`rx_level` after that edge > the `rx_thresh` sampled at that edge).
- R3: A flush strobe empties its queue (level 0) and clears that direction's overflow and underflow flags. The request is 0 in the cycle after the strobe. A push or pop in the same cycle as a flush is discarded.
- R4: One cycle after an edge where a DMA enable is 0, that direction's request is 0, whatever the level.
- R5: While a queue's enable is 0, its serial-side port has no effect. For the outbound queue that port is `ser_tx_pop`; for the inbound queue it is `ser_rx_push`. "No effect" means no level change, no data change and no flag. The bus-side port keeps working.
- R6: `tx_level` and `rx_level` equal the number of stored bytes, and they never exceed DEPTH.
- R7: After reset, both levels are 0 and both requests and all four error flags are 0.
- R8: A push to a full queue is dropped and sets that queue's sticky overflow flag. The stored bytes are unchanged.
- R9: A pop from an empty queue is dropped and sets that queue's sticky underflow flag. The level stays 0.
- R10: Each queue returns bytes in the order they were pushed. Its read-data output shows the oldest stored byte whenever the queue is not empty.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_fifo_en | input | 1 | Outbound queue serial-side enable |
| tx_dma_en | input | 1 | Outbound DMA request enable |
| tx_flush | input | 1 | One-cycle strobe that empties the outbound queue |
| tx_thresh | input | LW | Outbound low-water threshold |
| rx_fifo_en | input | 1 | Inbound queue serial-side enable |
| rx_dma_en | input | 1 | Inbound DMA request enable |
| rx_flush | input | 1 | One-cycle strobe that empties the inbound queue |
| rx_thresh | input | LW | Inbound high-water threshold |
| bus_tx_push | input | 1 | Bus writes a byte into the outbound queue |
| bus_tx_data | input | WIDTH | Byte written by the bus |
| ser_tx_pop | input | 1 | Shifter takes the oldest outbound byte |
| ser_tx_data | output | WIDTH | Oldest outbound byte |
| ser_rx_push | input | 1 | Shifter writes a byte into the inbound queue |
| ser_rx_data | input | WIDTH | Byte written by the shifter |
| bus_rx_pop | input | 1 | Bus takes the oldest inbound byte |
| bus_rx_data | output | WIDTH | Oldest inbound byte |
| tx_level | output | LW | Outbound occupancy |
| rx_level | output | LW | Inbound occupancy |
| tx_hit | output | 1 | Outbound threshold status |
| rx_hit | output | 1 | Inbound threshold status |
| tx_dma_req | output | 1 | Outbound DMA request |
| rx_dma_req | output | 1 | Inbound DMA request |
| tx_ovf | output | 1 | Sticky outbound overflow |
| tx_unf | output | 1 | Sticky outbound underflow |
| rx_ovf | output | 1 | Sticky inbound overflow |
| rx_unf | output | 1 | Sticky inbound underflow |

## Verification
The assertions assume that every control and strobe input is a known value at each rising edge after reset. They also assume that a threshold only matters as sampled at an edge, which is why the request checks compare against the previous cycle's threshold. The assertions make no assumption that flush lasts one cycle or that pushes and pops avoid full and empty queues; the bench deliberately pushes into full queues, pops from empty ones and flushes alongside pushes. The bench changes thresholds, enables and strobes only one time unit after a rising edge, so every input is stable well before the edge that samples it.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;

    typedef enum logic [1:0] {
        RQ_OFF    = 2'd0,
        RQ_WAIT   = 2'd1,
        RQ_ASSERT = 2'd2
    } req_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import fifo_dma_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [LW-1:0]    level,
    output logic [LW-1:0]    level_nxt,
    output logic             ovf,
    output logic             unf
);

    fill_state_e      fill_q, fill_d;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    count_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             is_empty, is_full, push_ok, pop_ok;

    assign is_empty = (fill_q == FS_EMPTY);
    assign is_full  = (fill_q == FS_FULL);
    assign push_ok  = push && !is_full && !flush;
    assign pop_ok   = pop && !is_empty && !flush;

    // occupancy state transitions
    always_comb begin
        fill_d = fill_q;
        unique case (fill_q)
            FS_EMPTY: begin
                if (push_ok) fill_d = (DEPTH == 1) ? FS_FULL : FS_PART;
            end
            FS_PART: begin
                if (flush)
                    fill_d = FS_EMPTY;
                else if (push_ok && !pop_ok && count_q == LW'(DEPTH - 1))
                    fill_d = FS_FULL;
                else if (pop_ok && !push_ok && count_q == LW'(1))
                    fill_d = FS_EMPTY;
            end
            FS_FULL: begin
                if (flush)
                    fill_d = FS_EMPTY;
                else if (pop_ok && !push_ok)
                    fill_d = (DEPTH == 1) ? FS_EMPTY : FS_PART;
            end
            default: fill_d = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= FS_EMPTY;
        else        fill_q <= fill_d;
    end

    // occupancy count
    always_comb begin
        unique case ({flush, push_ok, pop_ok})
            3'b010:  level_nxt = count_q + LW'(1);
            3'b001:  level_nxt = count_q - LW'(1);
            3'b000, 3'b011: level_nxt = count_q;
            default: level_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= level_nxt;
    end

    // pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (flush) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (push && is_full)  ovf <= 1'b1;
            if (pop && is_empty)  unf <= 1'b1;
        end
    end

    assign pop_data = mem[rd_ptr];
    assign level    = count_q;

    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    p_state_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FS_EMPTY) == (count_q == '0));
    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !ovf && !unf));
    p_full_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop && !flush) |=> ($stable(level) && ovf));
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !push && !flush) |=> (level == '0 && unf));
    p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !is_empty && !is_full && !flush) |=> $stable(level));

endmodule

// File: rtl/req_ctl.sv
module req_ctl
    import fifo_dma_pkg::*;
#(
    parameter dir_e DIR = DIR_TX,
    parameter int   LW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_en,
    input  logic          flush,
    input  logic [LW-1:0] thresh,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] level_nxt,
    output logic          hit,
    output logic          req
);

    req_state_e state_q, state_d;
    logic       cond_nxt;

    generate
        if (DIR == DIR_TX) begin : g_low_water
            assign hit      = (level < thresh);
            assign cond_nxt = (level_nxt < thresh);
            p_tx_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (dma_en && !flush) |=> (req == (level < $past(thresh))));
        end else begin : g_high_water
            assign hit      = (level > thresh);
            assign cond_nxt = (level_nxt > thresh);
            p_rx_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (dma_en && !flush) |=> (req == (level > $past(thresh))));
        end
    endgenerate

    // request state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_OFF, RQ_WAIT, RQ_ASSERT: begin
                if (!dma_en)       state_d = RQ_OFF;
                else if (flush)    state_d = RQ_WAIT;
                else if (cond_nxt) state_d = RQ_ASSERT;
                else               state_d = RQ_WAIT;
            end
            default: state_d = RQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RQ_ASSERT: req = 1'b1;
            default:   req = 1'b0;
        endcase
    end

    p_dma_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !req);
    p_flush_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !req);

endmodule

// File: rtl/fifo_dma_ctl.sv
module fifo_dma_ctl
    import fifo_dma_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_fifo_en,
    input  logic             tx_dma_en,
    input  logic             tx_flush,
    input  logic [LW-1:0]    tx_thresh,
    input  logic             rx_fifo_en,
    input  logic             rx_dma_en,
    input  logic             rx_flush,
    input  logic [LW-1:0]    rx_thresh,
    input  logic             bus_tx_push,
    input  logic [WIDTH-1:0] bus_tx_data,
    input  logic             ser_tx_pop,
    output logic [WIDTH-1:0] ser_tx_data,
    input  logic             ser_rx_push,
    input  logic [WIDTH-1:0] ser_rx_data,
    input  logic             bus_rx_pop,
    output logic [WIDTH-1:0] bus_rx_data,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic             tx_hit,
    output logic             rx_hit,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             tx_ovf,
    output logic             tx_unf,
    output logic             rx_ovf,
    output logic             rx_unf
);

    logic [LW-1:0] tx_level_nxt, rx_level_nxt;
    logic          tx_pop_gated, rx_push_gated;

    // serial side only acts while its queue is enabled
    assign tx_pop_gated  = ser_tx_pop && tx_fifo_en;
    assign rx_push_gated = ser_rx_push && rx_fifo_en;

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (bus_tx_push),
        .push_data (bus_tx_data),
        .pop       (tx_pop_gated),
        .pop_data  (ser_tx_data),
        .level     (tx_level),
        .level_nxt (tx_level_nxt),
        .ovf       (tx_ovf),
        .unf       (tx_unf)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push_gated),
        .push_data (ser_rx_data),
        .pop       (bus_rx_pop),
        .pop_data  (bus_rx_data),
        .level     (rx_level),
        .level_nxt (rx_level_nxt),
        .ovf       (rx_ovf),
        .unf       (rx_unf)
    );

    req_ctl #(.DIR(DIR_TX), .LW(LW)) u_tx_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (tx_dma_en),
        .flush     (tx_flush),
        .thresh    (tx_thresh),
        .level     (tx_level),
        .level_nxt (tx_level_nxt),
        .hit       (tx_hit),
        .req       (tx_dma_req)
    );

    req_ctl #(.DIR(DIR_RX), .LW(LW)) u_rx_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (rx_dma_en),
        .flush     (rx_flush),
        .thresh    (rx_thresh),
        .level     (rx_level),
        .level_nxt (rx_level_nxt),
        .hit       (rx_hit),
        .req       (rx_dma_req)
    );

    p_tx_serial_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_fifo_en && !bus_tx_push && !tx_flush) |=> ($stable(tx_level) && $stable(ser_tx_data)));
    p_rx_serial_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_fifo_en && !bus_rx_pop && !rx_flush) |=> $stable(rx_level));

endmodule

// File: tb/fifo_dma_ctl_bench.sv
`timescale 1ns/1ps
module fifo_dma_ctl_bench;
    localparam int D  = 8;
    localparam int W  = 8;
    localparam int LW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic tx_fifo_en, tx_dma_en, tx_flush, rx_fifo_en, rx_dma_en, rx_flush;
    logic [LW-1:0] tx_thresh, rx_thresh;
    logic bus_tx_push, ser_tx_pop, ser_rx_push, bus_rx_pop;
    logic [W-1:0] bus_tx_data, ser_tx_data, ser_rx_data, bus_rx_data;
    logic [LW-1:0] tx_level, rx_level;
    logic tx_hit, rx_hit, tx_dma_req, rx_dma_req, tx_ovf, tx_unf, rx_ovf, rx_unf;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    fifo_dma_ctl #(.DEPTH(D), .WIDTH(W)) u_fifo_dma_ctl (
        .clk(clk), .rst_n(rst_n),
        .tx_fifo_en(tx_fifo_en), .tx_dma_en(tx_dma_en), .tx_flush(tx_flush), .tx_thresh(tx_thresh),
        .rx_fifo_en(rx_fifo_en), .rx_dma_en(rx_dma_en), .rx_flush(rx_flush), .rx_thresh(rx_thresh),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_hit(tx_hit), .rx_hit(rx_hit),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tx_flush_pulse();
        tx_flush = 1'b1; tick(); tx_flush = 1'b0;
    endtask

    task automatic rx_flush_pulse();
        rx_flush = 1'b1; tick(); rx_flush = 1'b0;
    endtask

    task automatic tx_push(input int v);
        bus_tx_push = 1'b1; bus_tx_data = W'(v); tick(); bus_tx_push = 1'b0;
    endtask

    task automatic rx_push(input int v);
        ser_rx_push = 1'b1; ser_rx_data = W'(v); tick(); ser_rx_push = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {tx_fifo_en, tx_dma_en, tx_flush, rx_fifo_en, rx_dma_en, rx_flush} = '0;
        tx_thresh = '0; rx_thresh = '0;
        {bus_tx_push, ser_tx_pop, ser_rx_push, bus_rx_pop} = '0;
        bus_tx_data = '0; ser_rx_data = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R7 reset state
        chk("R7 tx_level", int'(tx_level), 0);
        chk("R7 rx_level", int'(rx_level), 0);
        chk("R7 tx_req", int'(tx_dma_req), 0);
        chk("R7 rx_req", int'(rx_dma_req), 0);
        chk("R7 flags", int'({tx_ovf, tx_unf, rx_ovf, rx_unf}), 0);

        tx_fifo_en = 1'b1; rx_fifo_en = 1'b1; tx_dma_en = 1'b1; rx_dma_en = 1'b1;

        // R1 / R6 sweep: every threshold against every level, outbound
        for (int thr = 0; thr <= D; thr++) begin
            for (int lv = 0; lv <= D; lv++) begin
                tx_flush_pulse();
                for (int i = 0; i < lv; i++) tx_push(i);
                tx_thresh = LW'(thr);
                tick();
                chk("R6 tx_level", int'(tx_level), lv);
                chk("R1 tx_hit", int'(tx_hit), int'(lv < thr));
                chk("R1 tx_req", int'(tx_dma_req), int'(lv < thr));
            end
        end

        // R2 / R6 sweep, inbound
        for (int thr = 0; thr <= D; thr++) begin
            for (int lv = 0; lv <= D; lv++) begin
                rx_flush_pulse();
                for (int i = 0; i < lv; i++) rx_push(i);
                rx_thresh = LW'(thr);
                tick();
                chk("R6 rx_level", int'(rx_level), lv);
                chk("R2 rx_hit", int'(rx_hit), int'(lv > thr));
                chk("R2 rx_req", int'(rx_dma_req), int'(lv > thr));
            end
        end

        // R10 order on both queues
        tx_flush_pulse(); rx_flush_pulse();
        for (int i = 0; i < 5; i++) begin tx_push(8'hA0 + i); rx_push(8'h50 + i); end
        for (int i = 0; i < 5; i++) begin
            chk("R10 tx head", int'(ser_tx_data), 8'hA0 + i);
            chk("R10 rx head", int'(bus_rx_data), 8'h50 + i);
            ser_tx_pop = 1'b1; bus_rx_pop = 1'b1; tick(); ser_tx_pop = 1'b0; bus_rx_pop = 1'b0;
        end
        chk("R10 tx drained", int'(tx_level), 0);

        // R11 simultaneous push and pop
        tx_flush_pulse();
        for (int i = 0; i < 3; i++) tx_push(8'h10 + i);
        bus_tx_push = 1'b1; bus_tx_data = 8'h77; ser_tx_pop = 1'b1; tick();
        bus_tx_push = 1'b0; ser_tx_pop = 1'b0;
        chk("R11 level", int'(tx_level), 3);
        chk("R11 head", int'(ser_tx_data), 8'h11);

        // R8 overflow
        tx_flush_pulse();
        for (int i = 0; i < D; i++) tx_push(i + 1);
        tx_push(8'hEE);
        chk("R8 level", int'(tx_level), D);
        chk("R8 ovf", int'(tx_ovf), 1);
        for (int i = 0; i < D; i++) begin
            chk("R8 data", int'(ser_tx_data), i + 1);
            ser_tx_pop = 1'b1; tick(); ser_tx_pop = 1'b0;
        end
        chk("R8 ovf sticky", int'(tx_ovf), 1);

        // R9 underflow
        rx_flush_pulse();
        bus_rx_pop = 1'b1; tick(); bus_rx_pop = 1'b0;
        chk("R9 rx_unf", int'(rx_unf), 1);
        chk("R9 rx_level", int'(rx_level), 0);
        ser_tx_pop = 1'b1; tick(); ser_tx_pop = 1'b0;
        chk("R9 tx_unf", int'(tx_unf), 1);

        // R3 flush clears flags, beats push, cancels request
        tx_flush_pulse();
        chk("R3 ovf cleared", int'(tx_ovf), 0);
        chk("R3 unf cleared", int'(tx_unf), 0);
        tx_push(1); tx_push(2);
        tx_flush = 1'b1; bus_tx_push = 1'b1; tick(); tx_flush = 1'b0; bus_tx_push = 1'b0;
        chk("R3 flush beats push", int'(tx_level), 0);
        tx_thresh = 4; tick();
        chk("R3 req before", int'(tx_dma_req), 1);
        tx_flush_pulse();
        chk("R3 req cancelled", int'(tx_dma_req), 0);
        tick();
        chk("R3 req resumes", int'(tx_dma_req), 1);

        // R4 DMA disable cancels
        tx_dma_en = 1'b0; tick();
        chk("R4 tx_req off", int'(tx_dma_req), 0);
        chk("R4 tx_hit kept", int'(tx_hit), 1);
        rx_flush_pulse(); rx_thresh = 1;
        for (int i = 0; i < 3; i++) rx_push(i);
        chk("R4 rx_req on", int'(rx_dma_req), 1);
        rx_dma_en = 1'b0; tick();
        chk("R4 rx_req off", int'(rx_dma_req), 0);

        // R5 serial side gated by queue enable
        tx_flush_pulse(); rx_flush_pulse();
        tx_fifo_en = 1'b0; rx_fifo_en = 1'b0;
        tx_push(8'h3C); tx_push(8'h3D);
        chk("R5 bus push works", int'(tx_level), 2);
        ser_tx_pop = 1'b1; tick(); ser_tx_pop = 1'b0;
        chk("R5 tx pop ignored", int'(tx_level), 2);
        chk("R5 tx data kept", int'(ser_tx_data), 8'h3C);
        chk("R5 tx no unf", int'(tx_unf), 0);
        rx_push(8'h99);
        chk("R5 rx push ignored", int'(rx_level), 0);
        chk("R5 rx no ovf", int'(rx_ovf), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule